// File: doc/BRIEF.md
# Smart Card Supervisor and Deactivation Sequencer

This block is the digital control core of a single-slot smart card interface. The host runs card activation itself. It picks a card supply voltage and then, once the block reports that the supply is good, it drives the card reset, clock and data lines through pass-through paths. All host-side inputs are captured only on clock edges where chip select is high, so several of these interfaces can share one set of host lines. The block watches card presence, through an active-high and an active-low detect input, and five fault flags: card over-current, low logic supply, low regulator supply, low card supply and over-temperature. On a fault, on card removal or on a change of voltage selection it takes the contacts away from the host. It then shuts the card down in a fixed order with a fixed spacing. The spacing is counted in ticks of a slow timing clock, which is derived from the system clock by a prescaler.

The sequencer has the states ST_IDLE, ST_RAMP, ST_ACTIVE, ST_DROP_RST, ST_DROP_CLK, ST_DROP_IO, ST_VOFF and ST_SLEEP. The transitions are as follows:
- idle→ramp: a voltage is selected, a card is present, no core fault is raised and power-down is not requested.
- idle→sleep: power-down is requested.
- sleep→idle: the power-down request is released.
- ramp→active: the synchronized supply-good input rises.
- ramp→voff: any exit condition. Only the supply is on in ramp, so dropping it is the whole sequence.
- active→drop_rst: any exit condition.
- drop_rst→drop_clk→drop_io→voff: each on the end of a step interval.
- voff→idle: the host has captured the "no voltage" selection.

The ready output is high only in ST_ACTIVE. The active-low interrupt output reports an absent card and latched faults.

Top module: `card_guard`

## Requirements
- R1: After reset, vcc_en, card_rst, card_clk, card_io, vreg_sel, rdy and sleep are all low.
- R2: The captured select pair {sel_b, sel_a} decodes to the one-hot vreg_sel as follows: 01 gives bit 0 (5 V), 10 gives bit 1 (3 V), 11 gives bit 2 (1.8 V) and 00 gives no supply. vreg_sel is zero whenever vcc_en is low, and at most one bit is ever set.
- R3: From idle, with a card present, no core fault and a nonzero selection captured, vcc_en rises one edge after the capture, while rst, clk and io stay low and rdy stays low. rdy rises, and all three card lines start to pass the host values, SYNC_STAGES+1 edges after vcc_good rises.
- R4: Host inputs (sel_a, sel_b, pwrdn, rst_in, clk_in, io_in) take effect only through edges where cs is high, and changes made while cs is low have no effect. card_clk follows clk_in combinationally while cs is high and holds the last captured clk_in while cs is low.
- R5: In ramp or active, any of these starts an emergency shutdown: card removal, over-current, low logic supply, low regulator supply, over-temperature, or a change of the captured selection to a different nonzero code. The low card supply flag triggers it only in active and is ignored in ramp.
- R6: An emergency shutdown from active drops card_rst on the first edge, card_clk T cycles later, card_io another T cycles later and vcc_en another T cycles later, where T = TICK_DIV*STEP_TICKS. rdy is low from the first edge on.
- R7: Presence, fault and vcc_good inputs pass SYNC_STAGES flops, so a fault raised before edge 1 starts the shutdown at edge SYNC_STAGES+1.
- R8: off_n is low while no card is detected. It is also low from the first edge of a fault- or removal-triggered shutdown until the host captures selection 00 after the shutdown has ended.
- R9: A host deselect (selection 00) or a power-down request during a session runs the same ordered shutdown, and off_n stays high.
- R10: After a shutdown the supply stays off until the host captures selection 00. The block then returns to idle on the next edge.
- R11: With pwrdn captured high in idle, sleep rises on the next edge, all card outputs and rdy stay low, and selections are ignored. Capturing pwrdn low returns the block to idle on the next edge.
- R12: A card is present when pres_hi is high or pres_lo_n is low.
- R13: In idle, no supply is enabled while no card is present or while a core fault (over-current, logic supply, regulator supply, over-temperature) is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; step timing is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; host inputs are captured on edges where it is high |
| sel_a | input | 1 | First voltage select input |
| sel_b | input | 1 | Second voltage select input |
| pwrdn | input | 1 | Power-down request |
| rst_in | input | 1 | Host image of the card reset line |
| clk_in | input | 1 | Host card clock, passed combinationally while cs is high |
| io_in | input | 1 | Host data drive, 1 releases the line high |
| pres_hi | input | 1 | Card detect, active high |
| pres_lo_n | input | 1 | Card detect, active low |
| flt_ocp | input | 1 | Card over-current flag |
| flt_vdd | input | 1 | Low logic supply flag |
| flt_vpc | input | 1 | Low regulator supply flag |
| flt_vcc | input | 1 | Low card supply flag |
| flt_temp | input | 1 | Over-temperature flag |
| vcc_good | input | 1 | Card supply has reached the selected level |
| card_rst | output | 1 | Card reset contact |
| card_clk | output | 1 | Card clock contact |
| card_io | output | 1 | Card data contact drive |
| vcc_en | output | 1 | Card supply enable |
| vreg_sel | output | 3 | One-hot regulator level: bit0 5 V, bit1 3 V, bit2 1.8 V |
| rdy | output | 1 | Supply valid, host may activate |
| off_n | output | 1 | Active-low interrupt: card absent or fault latched |
| sleep | output | 1 | Low-power state indication |

## Verification
A wrong sequencer state shows at the contacts within one cycle. The contact vector {vcc_en, card_io, card_clk, card_rst} has exactly one legal value per state, so a skipped or repeated drop state gives the wrong pattern at the next sample. A step timer that is off by even one cycle moves a contact edge away from its T-cycle boundary, and sampling on both sides of each boundary catches that. A fault latch that clears too early or never sets shows on off_n as soon as the shutdown starts or in the first cycles after the fault flag clears. A wrong stored session voltage shows on vreg_sel while the supply is on.

// File: rtl/card_guard_pkg.sv
package card_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_ACTIVE,
        ST_DROP_RST,
        ST_DROP_CLK,
        ST_DROP_IO,
        ST_VOFF,
        ST_SLEEP
    } seq_state_t;

    // {sel_b, sel_a}
    typedef enum logic [1:0] {
        VC_OFF = 2'b00,
        VC_5V  = 2'b01,
        VC_3V  = 2'b10,
        VC_1V8 = 2'b11
    } vcode_t;

    typedef struct packed {
        vcode_t sel;
        logic   pwrdn;
        logic   rst;
        logic   clk;
        logic   io;
    } host_cmd_t;

    typedef struct packed {
        logic pres_hi;
        logic pres_lo_act;
        logic ocp;
        logic vdd;
        logic vpc;
        logic vcc;
        logic temp;
        logic good;
    } mon_t;

    function automatic logic [2:0] vcode_onehot(vcode_t c);
        logic [2:0] r;
        unique case (c)
            VC_OFF: r = 3'b000;
            VC_5V:  r = 3'b001;
            VC_3V:  r = 3'b010;
            VC_1V8: r = 3'b100;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/cg_host_latch.sv
module cg_host_latch
    import card_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs,
    input  host_cmd_t d,
    output host_cmd_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cs) begin
            q <= d;
        end
    end
endmodule

// File: rtl/cg_step_timer.sv
module cg_step_timer #(
    parameter int TICK_DIV   = 4,
    parameter int STEP_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic step_done
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int CW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;

    logic          tick;
    logic [CW-1:0] cnt_q;

    generate
        if (TICK_DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clr || (pre_q == PW'(TICK_DIV - 1))) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + PW'(1);
                end
            end
            assign tick = (pre_q == PW'(TICK_DIV - 1));
        end
    endgenerate

    assign step_done = tick && (cnt_q == CW'(STEP_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || step_done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/cg_seq.sv
module cg_seq
    import card_guard_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   present,
    input  logic   core_fault,
    input  logic   vcc_fault,
    input  logic   vcc_good,
    input  vcode_t h_sel,
    input  logic   h_pwrdn,
    input  logic   step_done,
    output logic   en_rst,
    output logic   en_clk,
    output logic   en_io,
    output logic   vcc_en,
    output logic   rdy,
    output logic   sleep,
    output logic   tmr_clr,
    output logic   fault_q,
    output vcode_t sess_q
);
    seq_state_t state_q, state_d;
    vcode_t     sess_d;
    logic       fault_d;
    logic       in_session, sel_swap, fault_hit, quit;

    always_comb begin
        in_session = (state_q == ST_RAMP) || (state_q == ST_ACTIVE);
        sel_swap   = (h_sel != VC_OFF) && (h_sel != sess_q);
        fault_hit  = !present || core_fault || sel_swap ||
                     (vcc_fault && (state_q == ST_ACTIVE));
        quit       = fault_hit || (h_sel == VC_OFF) || h_pwrdn;
    end

    // next state
    always_comb begin
        state_d = state_q;
        sess_d  = sess_q;
        fault_d = fault_q;
        unique case (state_q)
            ST_IDLE: begin
                if (h_pwrdn) begin
                    state_d = ST_SLEEP;
                end else if ((h_sel != VC_OFF) && present && !core_fault) begin
                    state_d = ST_RAMP;
                    sess_d  = h_sel;
                end
            end
            ST_RAMP: begin
                if (quit) begin
                    state_d = ST_VOFF;
                end else if (vcc_good) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (quit) begin
                    state_d = ST_DROP_RST;
                end
            end
            ST_DROP_RST: begin
                if (step_done) begin
                    state_d = ST_DROP_CLK;
                end
            end
            ST_DROP_CLK: begin
                if (step_done) begin
                    state_d = ST_DROP_IO;
                end
            end
            ST_DROP_IO: begin
                if (step_done) begin
                    state_d = ST_VOFF;
                end
            end
            ST_VOFF: begin
                if (h_sel == VC_OFF) begin
                    state_d = ST_IDLE;
                    fault_d = 1'b0;
                end
            end
            ST_SLEEP: begin
                if (!h_pwrdn) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
        if (in_session && fault_hit) begin
            fault_d = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sess_q  <= VC_OFF;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sess_q  <= sess_d;
            fault_q <= fault_d;
        end
    end

    // outputs
    always_comb begin
        en_rst  = 1'b0;
        en_clk  = 1'b0;
        en_io   = 1'b0;
        vcc_en  = 1'b0;
        rdy     = 1'b0;
        sleep   = 1'b0;
        tmr_clr = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_VOFF: begin
            end
            ST_RAMP: begin
                vcc_en = 1'b1;
            end
            ST_ACTIVE: begin
                en_rst = 1'b1;
                en_clk = 1'b1;
                en_io  = 1'b1;
                vcc_en = 1'b1;
                rdy    = 1'b1;
            end
            ST_DROP_RST: begin
                en_clk  = 1'b1;
                en_io   = 1'b1;
                vcc_en  = 1'b1;
                tmr_clr = 1'b0;
            end
            ST_DROP_CLK: begin
                en_io   = 1'b1;
                vcc_en  = 1'b1;
                tmr_clr = 1'b0;
            end
            ST_DROP_IO: begin
                vcc_en  = 1'b1;
                tmr_clr = 1'b0;
            end
            ST_SLEEP: begin
                sleep = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/card_guard.sv
module card_guard
    import card_guard_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int STEP_TICKS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       sel_a,
    input  logic       sel_b,
    input  logic       pwrdn,
    input  logic       rst_in,
    input  logic       clk_in,
    input  logic       io_in,
    input  logic       pres_hi,
    input  logic       pres_lo_n,
    input  logic       flt_ocp,
    input  logic       flt_vdd,
    input  logic       flt_vpc,
    input  logic       flt_vcc,
    input  logic       flt_temp,
    input  logic       vcc_good,
    output logic       card_rst,
    output logic       card_clk,
    output logic       card_io,
    output logic       vcc_en,
    output logic [2:0] vreg_sel,
    output logic       rdy,
    output logic       off_n,
    output logic       sleep
);
    localparam int MON_W = $bits(mon_t);

    mon_t      mon_raw, mon_s;
    host_cmd_t cmd_d, cmd_q;
    vcode_t    sess;
    logic      present, core_fault;
    logic      en_rst, en_clk, en_io, tmr_clr, step_done, fault_q;

    assign mon_raw = '{pres_hi:     pres_hi,
                       pres_lo_act: !pres_lo_n,
                       ocp:         flt_ocp,
                       vdd:         flt_vdd,
                       vpc:         flt_vpc,
                       vcc:         flt_vcc,
                       temp:        flt_temp,
                       good:        vcc_good};

    cg_sync #(.WIDTH(MON_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (mon_raw),
        .q    (mon_s)
    );

    assign cmd_d = '{sel:   vcode_t'({sel_b, sel_a}),
                     pwrdn: pwrdn,
                     rst:   rst_in,
                     clk:   clk_in,
                     io:    io_in};

    cg_host_latch u_host (
        .clk  (clk),
        .rst_n(rst_n),
        .cs   (cs),
        .d    (cmd_d),
        .q    (cmd_q)
    );

    cg_step_timer #(.TICK_DIV(TICK_DIV), .STEP_TICKS(STEP_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .step_done(step_done)
    );

    assign present    = mon_s.pres_hi || mon_s.pres_lo_act;
    assign core_fault = mon_s.ocp || mon_s.vdd || mon_s.vpc || mon_s.temp;

    cg_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .present   (present),
        .core_fault(core_fault),
        .vcc_fault (mon_s.vcc),
        .vcc_good  (mon_s.good),
        .h_sel     (cmd_q.sel),
        .h_pwrdn   (cmd_q.pwrdn),
        .step_done (step_done),
        .en_rst    (en_rst),
        .en_clk    (en_clk),
        .en_io     (en_io),
        .vcc_en    (vcc_en),
        .rdy       (rdy),
        .sleep     (sleep),
        .tmr_clr   (tmr_clr),
        .fault_q   (fault_q),
        .sess_q    (sess)
    );

    assign card_rst = en_rst && cmd_q.rst;
    assign card_io  = en_io && cmd_q.io;
    assign card_clk = en_clk && (cs ? clk_in : cmd_q.clk);
    assign vreg_sel = vcc_en ? vcode_onehot(sess) : 3'b000;
    assign off_n    = present && !fault_q;
endmodule

// File: rtl/card_guard_chk.sv
module card_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_en,
    input logic       rdy,
    input logic       sleep,
    input logic       card_rst,
    input logic       card_clk,
    input logic       card_io,
    input logic [2:0] vreg_sel
);
    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vreg_sel));

    assert_sel_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_en |-> (vreg_sel == 3'b000));

    assert_rdy_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (vcc_en && !sleep));

    assert_ramp_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> (!rdy && !card_rst));

    assert_unpowered_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_en |-> (!card_rst && !card_clk && !card_io));

    assert_supply_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> $past(!card_io && !card_clk && !card_rst));

    assert_rst_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> !card_rst);

    assert_sleep_dark_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !vcc_en);
endmodule

bind card_guard card_guard_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vcc_en  (vcc_en),
    .rdy     (rdy),
    .sleep   (sleep),
    .card_rst(card_rst),
    .card_clk(card_clk),
    .card_io (card_io),
    .vreg_sel(vreg_sel)
);

// File: tb/card_guard_bench.sv
module card_guard_bench;
    localparam int CLK_P = 10;
    localparam int DIV   = 4;
    localparam int STEPS = 8;
    localparam int SYNC  = 2;
    localparam int T     = DIV * STEPS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sel_a = 1'b0, sel_b = 1'b0, pwrdn = 1'b0;
    logic rst_in = 1'b1, clk_in = 1'b1, io_in = 1'b1;
    logic pres_hi = 1'b1, pres_lo_n = 1'b1;
    logic flt_ocp = 1'b0, flt_vdd = 1'b0, flt_vpc = 1'b0, flt_vcc = 1'b1, flt_temp = 1'b0;
    logic vcc_good = 1'b0;
    logic card_rst, card_clk, card_io, vcc_en, rdy, off_n, sleep;
    logic [2:0] vreg_sel;

    int n_chk = 0;
    int n_bad = 0;

    card_guard #(.TICK_DIV(DIV), .STEP_TICKS(STEPS), .SYNC_STAGES(SYNC)) u_card_guard (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sel_a(sel_a), .sel_b(sel_b), .pwrdn(pwrdn),
        .rst_in(rst_in), .clk_in(clk_in), .io_in(io_in), .pres_hi(pres_hi),
        .pres_lo_n(pres_lo_n), .flt_ocp(flt_ocp), .flt_vdd(flt_vdd), .flt_vpc(flt_vpc),
        .flt_vcc(flt_vcc), .flt_temp(flt_temp), .vcc_good(vcc_good),
        .card_rst(card_rst), .card_clk(card_clk), .card_io(card_io), .vcc_en(vcc_en),
        .vreg_sel(vreg_sel), .rdy(rdy), .off_n(off_n), .sleep(sleep)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] contacts();
        return {vcc_en, card_io, card_clk, card_rst};
    endfunction

    function automatic logic [2:0] exp_onehot(logic [1:0] code);
        return (code == 2'd0) ? 3'd0 : 3'(1 << (code - 1));
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host(logic [1:0] code, logic pd);
        cs = 1'b1; sel_a = code[0]; sel_b = code[1]; pwrdn = pd;
        rst_in = 1'b1; clk_in = 1'b1; io_in = 1'b1;
    endtask

    task automatic idle_supply();
        vcc_good = 1'b0; flt_vcc = 1'b1;
        flt_ocp = 1'b0; flt_vdd = 1'b0; flt_vpc = 1'b0; flt_temp = 1'b0;
    endtask

    task automatic set_fault(int f);
        case (f)
            0: flt_ocp  = 1'b1;
            1: flt_vdd  = 1'b1;
            2: flt_vpc  = 1'b1;
            3: flt_vcc  = 1'b1;
            default: flt_temp = 1'b1;
        endcase
    endtask

    task automatic activate(logic [1:0] code);
        host(code, 1'b0);
        step(2);
        chk("R3 ramp contacts", 32'(contacts()), 32'h8);
        chk("R3 ramp rdy", 32'(rdy), 0);
        chk("R2 voltage decode", 32'(vreg_sel), 32'(exp_onehot(code)));
        step(4);
        chk("R5 low card supply masked in ramp", 32'(contacts()), 32'h8);
        chk("R5 off_n in ramp", 32'(off_n), 1);
        vcc_good = 1'b1; flt_vcc = 1'b0;
        step(SYNC);
        chk("R3 rdy not yet", 32'(rdy), 0);
        step(1);
        chk("R3 rdy", 32'(rdy), 1);
        chk("R3 pass-through", 32'(contacts()), 32'hF);
    endtask

    task automatic drop_seq(string tag, int lat, logic exp_off);
        step(lat);
        chk({tag, " R6/R7 rst drop"}, 32'(contacts()), 32'hE);
        chk({tag, " R6 rdy low"}, 32'(rdy), 0);
        chk({tag, " R8/R9 off_n"}, 32'(off_n), 32'(exp_off));
        step(T - 1);
        chk({tag, " R6 rst hold"}, 32'(contacts()), 32'hE);
        step(1);
        chk({tag, " R6 clk drop"}, 32'(contacts()), 32'hC);
        step(T - 1);
        chk({tag, " R6 clk hold"}, 32'(contacts()), 32'hC);
        step(1);
        chk({tag, " R6 io drop"}, 32'(contacts()), 32'h8);
        step(T - 1);
        chk({tag, " R6 io hold"}, 32'(contacts()), 32'h8);
        step(1);
        chk({tag, " R6 supply off"}, 32'(contacts()), 32'h0);
        chk({tag, " R2 level cleared"}, 32'(vreg_sel), 0);
        idle_supply();
    endtask

    task automatic deselect(string tag, logic exp_held);
        step(2);
        chk({tag, " R8 off_n held"}, 32'(off_n), 32'(exp_held));
        chk({tag, " R10 supply stays off"}, 32'(vcc_en), 0);
        host(2'b00, 1'b0);
        step(2);
        chk({tag, " R8/R10 off_n after deselect"}, 32'(off_n), 1);
        chk({tag, " R10 idle contacts"}, 32'(contacts()), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        chk("R1 contacts", 32'(contacts()), 0);
        chk("R1 rdy", 32'(rdy), 0);
        chk("R1 vreg_sel", 32'(vreg_sel), 0);
        chk("R1 sleep", 32'(sleep), 0);
        rst_n = 1'b1;
        step(3);
        chk("R12 active-high detect", 32'(off_n), 1);

        // fault sources x voltage levels
        for (int code = 1; code <= 3; code++) begin
            for (int f = 0; f < 5; f++) begin
                activate(2'(code));
                set_fault(f);
                drop_seq($sformatf("R5 fault%0d code%0d", f, code), SYNC + 1, 1'b0);
                deselect("R5", 1'b0);
            end
        end

        // removal, active-high detect
        activate(2'b01);
        pres_hi = 1'b0;
        drop_seq("R5 removal hi", SYNC + 1, 1'b0);
        pres_hi = 1'b1;
        deselect("R12 reinsert", 1'b0);

        // switch to active-low detect
        pres_hi = 1'b0; pres_lo_n = 1'b0;
        step(SYNC + 1);
        chk("R12 active-low detect", 32'(off_n), 1);
        activate(2'b10);
        pres_lo_n = 1'b1;
        drop_seq("R5 removal lo", SYNC + 1, 1'b0);
        pres_lo_n = 1'b0;
        deselect("R12 reinsert lo", 1'b0);
        pres_hi = 1'b1; pres_lo_n = 1'b1;
        step(SYNC + 1);

        // no card in idle
        pres_hi = 1'b0;
        step(SYNC + 1);
        chk("R8 off_n no card", 32'(off_n), 0);
        host(2'b01, 1'b0);
        step(4);
        chk("R13 no supply without card", 32'(vcc_en), 0);
        host(2'b00, 1'b0);
        pres_hi = 1'b1;
        step(SYNC + 1);

        // core fault in idle blocks start
        flt_temp = 1'b1;
        step(SYNC + 1);
        host(2'b11, 1'b0);
        step(4);
        chk("R13 no supply under fault", 32'(vcc_en), 0);
        flt_temp = 1'b0;
        step(SYNC + 1);
        chk("R13 start after fault clears", 32'(vcc_en), 1);
        chk("R2 1.8 V level", 32'(vreg_sel), 32'h4);
        host(2'b00, 1'b0);
        step(2);
        chk("R9 ramp abort supply off", 32'(vcc_en), 0);
        chk("R9 ramp abort off_n", 32'(off_n), 1);
        step(2);

        // selection change in session
        activate(2'b01);
        host(2'b10, 1'b0);
        drop_seq("R5 selection change", 2, 1'b0);
        deselect("R5 selection change", 1'b0);

        // host deselect in session
        activate(2'b11);
        host(2'b00, 1'b0);
        drop_seq("R9 host deselect", 2, 1'b1);
        deselect("R9 host deselect", 1'b1);

        // power-down in session then sleep
        activate(2'b10);
        host(2'b10, 1'b1);
        drop_seq("R9 power-down", 2, 1'b1);
        host(2'b00, 1'b1);
        step(3);
        chk("R11 sleep", 32'(sleep), 1);
        chk("R11 sleep rdy", 32'(rdy), 0);
        host(2'b01, 1'b1);
        step(4);
        chk("R11 selection ignored", 32'(vcc_en), 0);
        host(2'b01, 1'b0);
        step(3);
        chk("R11 wake sleep", 32'(sleep), 0);
        chk("R11 wake start", 32'(vcc_en), 1);
        host(2'b00, 1'b0);
        step(4);

        // chip select gating
        activate(2'b01);
        cs = 1'b0; sel_a = 1'b0; sel_b = 1'b0; pwrdn = 1'b1;
        rst_in = 1'b0; clk_in = 1'b0; io_in = 1'b0;
        step(4);
        chk("R4 held contacts", 32'(contacts()), 32'hF);
        chk("R4 held rdy", 32'(rdy), 1);
        chk("R4 held level", 32'(vreg_sel), 32'h1);
        cs = 1'b1; sel_a = 1'b1; pwrdn = 1'b0; rst_in = 1'b1; io_in = 1'b1; clk_in = 1'b0;
        #1;
        chk("R4 clock follows", 32'(card_clk), 0);
        clk_in = 1'b1;
        #1;
        chk("R4 clock follows high", 32'(card_clk), 1);
        step(1);
        host(2'b00, 1'b0);
        drop_seq("R4 exit", 2, 1'b1);
        step(2);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule